// File: doc/BRIEF.md
# Page Table Walker

This block resolves translation-cache misses in hardware for a single-level page table. When the translation cache reports a miss, the walker captures the virtual page number, the kind of access (read or write) and the table base address. It forms the address of the matching table entry by adding the page number, scaled by the entry size, to the base. It then issues one read on a valid/ready request channel and waits for the entry to come back on a response channel.

The returned entry is decoded and classified in a dedicated stage. There are three possible results: a fill of the translation cache with page number, frame number and permissions; a segmentation fault when the entry is not valid; or a protection fault when the entry is valid but does not permit the requested access. The outcome appears as a one-cycle done strobe. A retry strobe accompanies a successful fill so that the original access can be replayed and hit. Misses that arrive while a walk is in progress are ignored, and a busy output tells the requester when a new miss will be taken.

Top module: `ptw_engine`

## Requirements
- R1: After synchronous reset, busy, mem_req_valid, done, fill_valid and retry are low and fault_code is 00.
- R2: A miss_valid seen while not busy starts a walk. It captures miss_vpn, miss_is_write and pt_base in that cycle. In the next cycle it raises mem_req_valid with address pt_base + (miss_vpn << PTE_SIZE_LOG2), where PTE_SIZE_LOG2 defaults to 2.
- R3: The walker holds mem_req_valid and mem_req_addr steady until mem_req_ready is high. It drops the request in the cycle after acceptance, so each walk issues exactly one request.
- R4: After acceptance the walker waits any number of cycles for mem_rsp_valid and captures mem_rsp_data in the cycle it is high. Responses at any other time are ignored.
- R5: Entry layout: bit 0 is valid, bit 1 grants read, bit 2 grants write, and the top PFN_W bits hold the frame number (bits 31..12 by default).
- R6: An entry with bit 0 clear ends the walk with fault_code 01, whatever its permission bits are. No fill and no retry are signalled.
- R7: A valid entry that lacks the permission for the access ends the walk with fault_code 10, without fill or retry. A read needs bit 1 and a write needs bit 2.
- R8: Any other entry ends the walk with fill_valid and retry high and fault_code 00. fill_vpn carries the captured page number, fill_pfn the frame number, and fill_rd and fill_wr the entry's bits 1 and 2.
- R9: done, together with any fault code, fill or retry, is high for exactly one cycle: the second cycle after the response is captured.
- R10: busy is high from the cycle after a miss is taken through the done cycle, and is low after it. A miss_valid during a walk has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation-cache miss report |
| miss_vpn | input | VPN_W (20) | Virtual page number that missed |
| miss_is_write | input | 1 | Missing access is a write (1) or read (0) |
| pt_base | input | PA_W (32) | Physical base address of the page table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Table-entry read request valid |
| mem_req_addr | output | PA_W (32) | Address of the table entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Returned entry valid |
| mem_rsp_data | input | PTE_W (32) | Returned table entry |
| fill_valid | output | 1 | Write translation into the cache |
| fill_vpn | output | VPN_W (20) | Page number for the fill |
| fill_pfn | output | PFN_W (20) | Frame number for the fill |
| fill_rd | output | 1 | Read permission for the fill |
| fill_wr | output | 1 | Write permission for the fill |
| done | output | 1 | Walk finished strobe |
| fault_code | output | 2 | 00 none, 01 segmentation, 10 protection |
| retry | output | 1 | Original access may be replayed |

## Verification
The hardest case to reach from the ports is a second miss that arrives while the walker is still waiting on memory. Only an ignored miss shows whether the captured page number and access kind are protected during the wait. The stimulus holds miss_valid high with a different page number and access kind through the wait and classify stages. It then checks that the fill reports the first page number and the first access kind's permission outcome. Back-pressure on mem_req_ready and long response delays are driven for several cycles each, and the request is checked for stability in every stalled cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CHECK = 3'd3,
        ST_DONE  = 3'd4
    } ptw_state_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_SEG  = 2'b01,
        FLT_PROT = 2'b10
    } ptw_fault_e;

    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_READ_BIT  = 1;
    localparam int PTE_WRITE_BIT = 2;
    localparam int PTE_FLAG_BITS = 3;

    typedef struct packed {
        logic valid;
        logic rd;
        logic wr;
    } pte_flags_t;

    function automatic ptw_fault_e classify(pte_flags_t f, logic is_write);
        ptw_fault_e code;
        if (!f.valid)
            code = FLT_SEG;
        else if (is_write ? !f.wr : !f.rd)
            code = FLT_PROT;
        else
            code = FLT_NONE;
        return code;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W          = 32,
    parameter int VPN_W         = 20,
    parameter int PTE_SIZE_LOG2 = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] vpn_ext;
    logic [PA_W-1:0] offset;

    assign vpn_ext = PA_W'(vpn);
    assign offset  = vpn_ext << PTE_SIZE_LOG2;
    assign addr    = base + offset;
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PFN_W = 20
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output logic [PFN_W-1:0] pfn,
    output pte_flags_t       flags,
    output ptw_fault_e       code
);
    localparam int RSVD_W = PTE_W - PFN_W - PTE_FLAG_BITS;

    assign flags.valid = pte[PTE_VALID_BIT];
    assign flags.rd    = pte[PTE_READ_BIT];
    assign flags.wr    = pte[PTE_WRITE_BIT];
    assign pfn         = pte[PTE_W-1 -: PFN_W];
    assign code        = classify(flags, is_write);

    generate
        if (RSVD_W > 0) begin : g_rsvd
            logic [RSVD_W-1:0] rsvd_unused;
            assign rsvd_unused = pte[PTE_FLAG_BITS +: RSVD_W];
        end
    endgenerate
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic miss_valid,
    input  logic mem_req_ready,
    input  logic mem_rsp_valid,
    output logic miss_take,
    output logic rsp_take,
    output logic chk_stage,
    output logic done_stage,
    output logic req_active,
    output logic busy
);
    ptw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (miss_valid)    state_d = ST_REQ;
            ST_REQ:   if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign miss_take  = (state_q == ST_IDLE) && miss_valid;
    assign rsp_take   = (state_q == ST_WAIT) && mem_rsp_valid;
    assign chk_stage  = (state_q == ST_CHECK);
    assign done_stage = (state_q == ST_DONE);
    assign req_active = (state_q == ST_REQ);
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
    import ptw_pkg::*;
#(
    parameter int VA_W          = 32,
    parameter int PA_W          = 32,
    parameter int PAGE_SHIFT    = 12,
    parameter int PTE_W         = 32,
    parameter int PTE_SIZE_LOG2 = 2,
    localparam int VPN_W        = VA_W - PAGE_SHIFT,
    localparam int PFN_W        = PA_W - PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic             miss_is_write,
    input  logic [PA_W-1:0]  pt_base,
    output logic             busy,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             fill_valid,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             fill_rd,
    output logic             fill_wr,
    output logic             done,
    output logic [1:0]       fault_code,
    output logic             retry
);
    logic miss_take, rsp_take, chk_stage, done_stage, req_active;

    logic [VPN_W-1:0] vpn_q;
    logic             wr_q;
    logic [PA_W-1:0]  addr_q, addr_d;
    logic [PTE_W-1:0] pte_q;
    ptw_fault_e       code_q, chk_code;
    logic [PFN_W-1:0] pfn_q, chk_pfn;
    pte_flags_t       flags_q, chk_flags;

    ptw_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .miss_valid    (miss_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .miss_take     (miss_take),
        .rsp_take      (rsp_take),
        .chk_stage     (chk_stage),
        .done_stage    (done_stage),
        .req_active    (req_active),
        .busy          (busy)
    );

    ptw_addr_gen #(
        .PA_W          (PA_W),
        .VPN_W         (VPN_W),
        .PTE_SIZE_LOG2 (PTE_SIZE_LOG2)
    ) u_addr (
        .base (pt_base),
        .vpn  (miss_vpn),
        .addr (addr_d)
    );

    ptw_pte_check #(
        .PTE_W (PTE_W),
        .PFN_W (PFN_W)
    ) u_check (
        .pte      (pte_q),
        .is_write (wr_q),
        .pfn      (chk_pfn),
        .flags    (chk_flags),
        .code     (chk_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            pte_q   <= '0;
            code_q  <= FLT_NONE;
            pfn_q   <= '0;
            flags_q <= '0;
        end else begin
            if (miss_take) begin
                vpn_q  <= miss_vpn;
                wr_q   <= miss_is_write;
                addr_q <= addr_d;
            end
            if (rsp_take)
                pte_q <= mem_rsp_data;
            if (chk_stage) begin
                code_q  <= chk_code;
                pfn_q   <= chk_pfn;
                flags_q <= chk_flags;
            end
        end
    end

    assign mem_req_valid = req_active;
    assign mem_req_addr  = addr_q;

    assign done       = done_stage;
    assign fault_code = done_stage ? code_q : FLT_NONE;
    assign fill_valid = done_stage && (code_q == FLT_NONE);
    assign retry      = done_stage && (code_q == FLT_NONE);
    assign fill_vpn   = vpn_q;
    assign fill_pfn   = pfn_q;
    assign fill_rd    = flags_q.rd;
    assign fill_wr    = flags_q.wr;
endmodule

// File: rtl/ptw_engine_chk.sv
module ptw_engine_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            miss_valid,
    input logic            busy,
    input logic            mem_req_valid,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            mem_req_ready,
    input logic            fill_valid,
    input logic            done,
    input logic [1:0]      fault_code,
    input logic            retry
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> busy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    fill_ok_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> done && (fault_code == 2'b00));

    // R8
    retry_fill_chk: assert property (@(posedge clk) disable iff (rst)
        retry |-> fill_valid);

    // R6
    fault_done_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_code != 2'b00) |-> done && !fill_valid && !retry);

    // R7
    code_legal_chk: assert property (@(posedge clk) disable iff (rst)
        fault_code != 2'b11);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && miss_valid |=> busy);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy ##1 !busy);
endmodule

bind ptw_engine ptw_engine_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .fill_valid    (fill_valid),
    .done          (done),
    .fault_code    (fault_code),
    .retry         (retry)
);

// File: tb/ptw_engine_tb_top.sv
`timescale 1ns/1ps
module ptw_engine_tb_top;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int PA_W  = 32;
    localparam int PTE_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             miss_valid = 1'b0;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic             miss_is_write = 1'b0;
    logic [PA_W-1:0]  pt_base = '0;
    logic             busy;
    logic             mem_req_valid;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_req_ready = 1'b0;
    logic             mem_rsp_valid = 1'b0;
    logic [PTE_W-1:0] mem_rsp_data = '0;
    logic             fill_valid;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic             fill_rd, fill_wr, done, retry;
    logic [1:0]       fault_code;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ptw_engine dut_i (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .miss_is_write(miss_is_write), .pt_base(pt_base), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_rd(fill_rd), .fill_wr(fill_wr), .done(done),
        .fault_code(fault_code), .retry(retry)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy", busy, 0);
        check("R1", "mem_req_valid", mem_req_valid, 0);
        check("R1", "done", done, 0);
        check("R1", "fault_code", fault_code, 0);
        check("R1", "fill_valid", fill_valid, 0);
        check("R1", "retry", retry, 0);
    endtask

    // One complete walk; intrude drives a second miss during the wait (R10)
    task automatic t_walk(input logic [VPN_W-1:0] vpn, input logic is_wr,
                          input logic [PA_W-1:0] base, input logic [PTE_W-1:0] pte,
                          input int rdy_dly, input int rsp_dly, input bit intrude);
        logic [PA_W-1:0] exp_addr;
        logic [1:0]      exp_code;
        exp_addr = base + ({12'b0, vpn} << 2);
        if (!pte[0])                       exp_code = 2'b01;
        else if (is_wr ? !pte[2] : !pte[1]) exp_code = 2'b10;
        else                                exp_code = 2'b00;

        @(negedge clk);
        miss_valid = 1'b1; miss_vpn = vpn; miss_is_write = is_wr; pt_base = base;
        @(negedge clk);
        miss_valid = 1'b0; miss_vpn = ~vpn; miss_is_write = ~is_wr; pt_base = ~base;
        check("R10", "busy after miss", busy, 1);
        check("R2", "req valid", mem_req_valid, 1);
        check("R2", "req addr", mem_req_addr, exp_addr);
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            check("R3", "req held valid", mem_req_valid, 1);
            check("R3", "req held addr", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check("R3", "req dropped", mem_req_valid, 0);
        if (intrude) begin
            miss_valid = 1'b1; miss_vpn = vpn ^ 20'h5A5A5; miss_is_write = ~is_wr;
        end
        for (int i = 0; i < rsp_dly; i++) begin
            @(negedge clk);
            check("R4", "no req while waiting", mem_req_valid, 0);
            check("R4", "no done while waiting", done, 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = ~pte;
        miss_valid = 1'b0;
        check("R9", "done not yet", done, 0);
        @(negedge clk);
        check("R9", "done strobe", done, 1);
        check("R10", "busy at done", busy, 1);
        check(exp_code == 2'b01 ? "R6" : exp_code == 2'b10 ? "R7" : "R8",
              "fault_code", fault_code, exp_code);
        check("R8", "fill_valid", fill_valid, exp_code == 2'b00);
        check("R8", "retry", retry, exp_code == 2'b00);
        if (exp_code == 2'b00) begin
            check("R8", "fill_vpn", fill_vpn, vpn);
            check("R5", "fill_pfn", fill_pfn, pte[31:12]);
            check("R5", "fill_rd", fill_rd, pte[1]);
            check("R5", "fill_wr", fill_wr, pte[2]);
        end
        @(negedge clk);
        check("R9", "done single cycle", done, 0);
        check("R10", "busy cleared", busy, 0);
        check("R9", "fault cleared", fault_code, 0);
    endtask

    // R4: responses outside a walk are ignored
    task automatic t_stray_response;
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R4", "stray rsp busy", busy, 0);
        check("R4", "stray rsp done", done, 0);
        t_walk(20'h00042, 1'b0, 32'h0010_0000, 32'hABCDE003, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        // R8 read hit
        t_walk(20'h00001, 1'b0, 32'h8000_0000, 32'h12345003, 0, 0, 0);
        // R8 write with full permissions, back-pressure and slow memory
        t_walk(20'h3_0F0F, 1'b1, 32'h0004_0000, 32'hFEDCB007, 3, 5, 0);
        // R6 invalid entry with all permissions
        t_walk(20'h00777, 1'b0, 32'h0000_1000, 32'h11111006, 1, 0, 0);
        // R6 invalid entry, write access
        t_walk(20'h00778, 1'b1, 32'h0000_1000, 32'h22222000, 0, 2, 0);
        // R7 write without write permission
        t_walk(20'h00100, 1'b1, 32'h0200_0000, 32'h33333003, 0, 1, 0);
        // R7 read without read permission
        t_walk(20'h00101, 1'b0, 32'h0200_0000, 32'h44444005, 2, 0, 0);
        // R8 write-only entry used for a write
        t_walk(20'h00102, 1'b1, 32'h0200_0000, 32'h55555005, 0, 0, 0);
        // R2 largest page number
        t_walk(20'hFFFFF, 1'b0, 32'h4000_0000, 32'h66666003, 0, 0, 0);
        // R10 miss during walk is ignored
        t_walk(20'h0ABCD, 1'b0, 32'h0008_0000, 32'h77777003, 1, 4, 1);
        t_walk(20'h0ABCE, 1'b1, 32'h0008_0000, 32'h88888003, 0, 3, 1);
        t_stray_response();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule